// File: doc/BRIEF.md
# Multi-Match Associative Lookup Array

This block is a small associative lookup array. It holds a set of words, each with its own valid bit. A single key can be compared against every stored word in the same cycle. A write loads one word into a chosen slot. The write is committed by a two-state write machine, so the new word can be searched on the second clock edge after the request. A search request is accepted only while no write is pending. Its result is registered and is presented one cycle after acceptance, with a one-cycle valid strobe.

A parameter chooses one of three result formats. The all-hits format gives a vector with one bit per slot. The first-hit one-hot format keeps only the lowest matching slot's bit. The first-hit binary format gives the lowest matching slot number. A synchronous clear invalidates every slot in a single cycle.

Two state machines control the block:

- **Write machine.** In `WR_IDLE`, an accepted write request moves it to `WR_COMMIT` (transition *capture*). From `WR_COMMIT` it always returns to `WR_IDLE` (transition *commit*, or *cancel* when a clear arrives in that cycle).
- **Search machine.** An accepted search moves it from `SR_IDLE` to `SR_SHOW` (*accept*). A further accepted search keeps it in `SR_SHOW` (*re-accept*). A cycle with no accepted search returns it to `SR_IDLE` (*retire*).

Top module: `assoc_cam`

## Requirements
- R1: After reset all slots are invalid, `res_valid` and `wr_busy` are low and `srch_ready` is high.
- R2: A write request seen while `wr_busy` is low is taken at that clock edge. `wr_busy` is then high for exactly one cycle. The slot holds the new word, marked valid, from the second edge after the request.
- R3: A write request presented while `wr_busy` is high is ignored and changes no slot.
- R4: `srch_ready` is low exactly while `wr_busy` is high. A search is taken only when `srch_req` and `srch_ready` are both high. `res_valid` is high for one cycle, in the cycle after acceptance. The result outputs hold their value until the next accepted search.
- R5: In all-hits mode (MODE=0), bit i of `res_vec` is 1 exactly when slot i is valid and equals the key. For example, with the key 4'b1100 stored only in slots 0 and 1, the low four bits of the vector read 0011. `res_addr` reads zero in this mode.
- R6: A slot whose valid bit is clear never matches. While `clear_all` is high, the next edge clears every valid bit and cancels a write that is waiting to commit. A write request presented in that same cycle is dropped.
- R7: In first-hit one-hot mode (MODE=1), `res_vec` has at most one bit set. That bit belongs to the lowest-numbered matching slot. `res_addr` reads zero in this mode.
- R8: In first-hit binary mode (MODE=2), `res_addr` gives the lowest-numbered matching slot and `res_vec` reads zero. With no match, `res_addr` is zero and `res_found` is low.
- R9: When a search and a write are accepted at the same edge, the search compares against the contents from before that write.
- R10: In every mode, `res_found` is high exactly when at least one valid slot equals the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_all | input | 1 | Synchronous invalidate of all slots |
| wr_req | input | 1 | Write request |
| wr_idx | input | IDXW | Slot to write |
| wr_word | input | WIDTH | Word to store |
| wr_busy | output | 1 | Write waiting to commit |
| srch_req | input | 1 | Search request |
| srch_key | input | WIDTH | Search key |
| srch_ready | output | 1 | Search can be accepted |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_vec | output | ENTRIES | Hit vector (all-hits or one-hot mode) |
| res_addr | output | IDXW | Lowest matching slot (binary mode) |
| res_found | output | 1 | At least one slot matched |

## Verification
A write request and a search request can be taken at the same clock edge. A clear can also land in the same cycle as a pending commit. The bench raises the write and search requests together, using a key equal to the word being written. It expects a result with no hit for that slot, and then a hit on the following search. It also raises `clear_all` while a write is in `WR_COMMIT`. It then searches for that word and expects no match and an idle write machine. Three instances, one per result format, receive identical stimulus. Every result is compared against a slot model kept in the bench.

// File: rtl/assoc_cam_pkg.sv
package assoc_cam_pkg;

    localparam int RES_ALL_HITS  = 0;
    localparam int RES_FIRST_HOT = 1;
    localparam int RES_FIRST_BIN = 2;

    typedef enum logic {
        WR_IDLE   = 1'b0,
        WR_COMMIT = 1'b1
    } wr_state_t;

    typedef enum logic {
        SR_IDLE = 1'b0,
        SR_SHOW = 1'b1
    } sr_state_t;

endpackage

// File: rtl/assoc_cam_store.sv
module assoc_cam_store
    import assoc_cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clear_all,
    input  logic                             wr_req,
    input  logic [IDXW-1:0]                  wr_idx,
    input  logic [WIDTH-1:0]                 wr_word,
    output logic                             wr_busy,
    output logic [ENTRIES-1:0][WIDTH-1:0]    slot_data,
    output logic [ENTRIES-1:0]               slot_valid
);

    wr_state_t        state_q, state_d;
    logic [IDXW-1:0]  pend_idx_q;
    logic [WIDTH-1:0] pend_word_q;
    logic             take_req;
    logic             commit_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE:   state_d = (wr_req && !clear_all) ? WR_COMMIT : WR_IDLE;
            WR_COMMIT: state_d = WR_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        wr_busy   = 1'b0;
        take_req  = 1'b0;
        commit_en = 1'b0;
        unique case (state_q)
            WR_IDLE:   take_req = wr_req && !clear_all;
            WR_COMMIT: begin
                wr_busy   = 1'b1;
                commit_en = !clear_all;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (take_req) begin
            pend_idx_q  <= wr_idx;
            pend_word_q <= wr_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            slot_valid <= '0;
        else if (clear_all)
            slot_valid <= '0;
        else if (commit_en)
            slot_valid[pend_idx_q] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (commit_en) slot_data[pend_idx_q] <= pend_word_q;
    end

endmodule

// File: rtl/assoc_cam_compare.sv
module assoc_cam_compare #(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32
) (
    input  logic [ENTRIES-1:0][WIDTH-1:0] slot_data,
    input  logic [ENTRIES-1:0]            slot_valid,
    input  logic [WIDTH-1:0]              key,
    output logic [ENTRIES-1:0]            hit
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_lane
        assign hit[g] = slot_valid[g] && (slot_data[g] == key);
    end

endmodule

// File: rtl/assoc_cam_encode.sv
module assoc_cam_encode
    import assoc_cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int MODE    = RES_ALL_HITS,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] hit,
    output logic [ENTRIES-1:0] enc_vec,
    output logic [IDXW-1:0]    enc_addr,
    output logic               enc_found
);

    assign enc_found = |hit;

    if (MODE == RES_ALL_HITS) begin : g_all
        assign enc_vec  = hit;
        assign enc_addr = '0;
    end else if (MODE == RES_FIRST_HOT) begin : g_hot
        // isolate lowest set bit
        assign enc_vec  = hit & (~hit + ENTRIES'(1));
        assign enc_addr = '0;
    end else begin : g_bin
        logic [IDXW-1:0] low_idx;
        always_comb begin
            low_idx = '0;
            for (int i = ENTRIES - 1; i >= 0; i--) begin
                if (hit[i]) low_idx = IDXW'(i);
            end
        end
        assign enc_vec  = '0;
        assign enc_addr = low_idx;
    end

endmodule

// File: rtl/assoc_cam.sv
module assoc_cam
    import assoc_cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    parameter int MODE    = RES_ALL_HITS,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_all,
    input  logic               wr_req,
    input  logic [IDXW-1:0]    wr_idx,
    input  logic [WIDTH-1:0]   wr_word,
    output logic               wr_busy,
    input  logic               srch_req,
    input  logic [WIDTH-1:0]   srch_key,
    output logic               srch_ready,
    output logic               res_valid,
    output logic [ENTRIES-1:0] res_vec,
    output logic [IDXW-1:0]    res_addr,
    output logic               res_found
);

    logic [ENTRIES-1:0][WIDTH-1:0] slot_data;
    logic [ENTRIES-1:0]            slot_valid;
    logic [ENTRIES-1:0]            hit;
    logic [ENTRIES-1:0]            enc_vec;
    logic [IDXW-1:0]               enc_addr;
    logic                          enc_found;
    logic                          accept;
    sr_state_t                     sr_q, sr_d;

    assoc_cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_all (clear_all),
        .wr_req    (wr_req),
        .wr_idx    (wr_idx),
        .wr_word   (wr_word),
        .wr_busy   (wr_busy),
        .slot_data (slot_data),
        .slot_valid(slot_valid)
    );

    assoc_cam_compare #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_cmp (
        .slot_data (slot_data),
        .slot_valid(slot_valid),
        .key       (srch_key),
        .hit       (hit)
    );

    assoc_cam_encode #(.ENTRIES(ENTRIES), .MODE(MODE)) u_enc (
        .hit      (hit),
        .enc_vec  (enc_vec),
        .enc_addr (enc_addr),
        .enc_found(enc_found)
    );

    assign srch_ready = !wr_busy;
    assign accept     = srch_req && srch_ready;

    // search state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= SR_IDLE;
        else        sr_q <= sr_d;
    end

    always_comb begin
        sr_d = sr_q;
        unique case (sr_q)
            SR_IDLE: sr_d = accept ? SR_SHOW : SR_IDLE;
            SR_SHOW: sr_d = accept ? SR_SHOW : SR_IDLE;
        endcase
    end

    // search outputs
    always_comb begin
        res_valid = 1'b0;
        unique case (sr_q)
            SR_IDLE: res_valid = 1'b0;
            SR_SHOW: res_valid = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_vec   <= '0;
            res_addr  <= '0;
            res_found <= 1'b0;
        end else if (accept) begin
            res_vec   <= enc_vec;
            res_addr  <= enc_addr;
            res_found <= enc_found;
        end
    end

endmodule

// File: rtl/assoc_cam_sva.sv
module assoc_cam_sva
    import assoc_cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int MODE    = RES_ALL_HITS,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clear_all,
    input logic               wr_req,
    input logic               wr_busy,
    input logic               srch_req,
    input logic               srch_ready,
    input logic               res_valid,
    input logic [ENTRIES-1:0] res_vec,
    input logic [IDXW-1:0]    res_addr,
    input logic               res_found
);

    a_r2_busy_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |=> !wr_busy);

    a_r2_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(wr_req && !clear_all));

    a_r4_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(srch_req && srch_ready));

    a_r4_refused_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_req && wr_busy) |=> !res_valid);

    a_r6_clear_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clear_all) && srch_req && srch_ready) |=> !res_found);

    a_r7_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE != RES_ALL_HITS && res_valid) |-> $onehot0(res_vec));

    a_r8_miss_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == RES_FIRST_BIN && res_valid && !res_found) |-> (res_addr == '0));

    a_r10_found_matches_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE != RES_FIRST_BIN && res_valid) |-> (res_found == (res_vec != '0)));

endmodule

bind assoc_cam assoc_cam_sva #(.ENTRIES(ENTRIES), .MODE(MODE)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_all (clear_all),
    .wr_req    (wr_req),
    .wr_busy   (wr_busy),
    .srch_req  (srch_req),
    .srch_ready(srch_ready),
    .res_valid (res_valid),
    .res_vec   (res_vec),
    .res_addr  (res_addr),
    .res_found (res_found)
);

// File: tb/assoc_cam_bench.sv
`timescale 1ns/1ps
module assoc_cam_bench;

    localparam int N  = 16;
    localparam int W  = 32;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_all = 1'b0;
    logic wr_req = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [W-1:0] wr_word = '0;
    logic srch_req = 1'b0;
    logic [W-1:0] srch_key = '0;

    logic          busy0, busy1, busy2, rdy0, rdy1, rdy2, v0, v1, v2, f0, f1, f2;
    logic [N-1:0]  vec0, vec1, vec2;
    logic [IW-1:0] ad0, ad1, ad2;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [W-1:0] m_data [N];
    logic         m_val  [N];

    always #2.5 clk = ~clk;

    assoc_cam #(.ENTRIES(N), .WIDTH(W), .MODE(0)) u_assoc_cam (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .wr_req(wr_req),
        .wr_idx(wr_idx), .wr_word(wr_word), .wr_busy(busy0), .srch_req(srch_req),
        .srch_key(srch_key), .srch_ready(rdy0), .res_valid(v0), .res_vec(vec0),
        .res_addr(ad0), .res_found(f0));

    assoc_cam #(.ENTRIES(N), .WIDTH(W), .MODE(1)) u_assoc_cam_hot (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .wr_req(wr_req),
        .wr_idx(wr_idx), .wr_word(wr_word), .wr_busy(busy1), .srch_req(srch_req),
        .srch_key(srch_key), .srch_ready(rdy1), .res_valid(v1), .res_vec(vec1),
        .res_addr(ad1), .res_found(f1));

    assoc_cam #(.ENTRIES(N), .WIDTH(W), .MODE(2)) u_assoc_cam_bin (
        .clk(clk), .rst_n(rst_n), .clear_all(clear_all), .wr_req(wr_req),
        .wr_idx(wr_idx), .wr_word(wr_word), .wr_busy(busy2), .srch_req(srch_req),
        .srch_key(srch_key), .srch_ready(rdy2), .res_valid(v2), .res_vec(vec2),
        .res_addr(ad2), .res_found(f2));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_busy(input string tag, input logic exp);
        check({tag, " busy0"}, 64'(busy0), 64'(exp));
        check({tag, " busy1"}, 64'(busy1), 64'(exp));
        check({tag, " busy2"}, 64'(busy2), 64'(exp));
        check({tag, " ready"}, 64'({rdy0, rdy1, rdy2}), exp ? 64'd0 : 64'd7);
    endtask

    // expected result of searching key against the bench model
    task automatic check_result(input string tag, input logic [W-1:0] key);
        logic [N-1:0] ev, eh;
        logic [IW-1:0] ea;
        ev = '0; eh = '0; ea = '0;
        for (int i = 0; i < N; i++) if (m_val[i] && m_data[i] == key) ev[i] = 1'b1;
        for (int i = N - 1; i >= 0; i--) if (ev[i]) begin eh = '0; eh[i] = 1'b1; ea = IW'(i); end
        check({tag, " R4 valid"}, 64'({v0, v1, v2}), 64'd7);
        check({tag, " R5 all-hits vec"}, 64'(vec0), 64'(ev));
        check({tag, " R5 all-hits addr"}, 64'(ad0), 64'd0);
        check({tag, " R7 one-hot vec"}, 64'(vec1), 64'(eh));
        check({tag, " R7 one-hot addr"}, 64'(ad1), 64'd0);
        check({tag, " R8 binary addr"}, 64'(ad2), 64'(ea));
        check({tag, " R8 binary vec"}, 64'(vec2), 64'd0);
        check({tag, " R10 found"}, 64'({f0, f1, f2}), (ev != '0) ? 64'd7 : 64'd0);
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic do_write(input logic [IW-1:0] idx, input logic [W-1:0] word);
        wr_req = 1'b1; wr_idx = idx; wr_word = word;
        @(negedge clk);
        wr_req = 1'b0;
        check_busy("R2 write pending", 1'b1);
        @(negedge clk);
        check_busy("R2 write done", 1'b0);
        m_data[idx] = word; m_val[idx] = 1'b1;
    endtask

    task automatic do_search(input string tag, input logic [W-1:0] key);
        srch_req = 1'b1; srch_key = key;
        @(negedge clk);
        srch_req = 1'b0;
        check_result(tag, key);
    endtask

    task automatic t_reset;
        check_busy("R1 reset", 1'b0);
        check("R1 reset valid", 64'({v0, v1, v2}), 64'd0);
        do_search("R1 R6 empty search", '0);
    endtask

    task automatic t_multi;
        do_write(4'd3, 32'hA5A5_0001);
        do_write(4'd7, 32'hA5A5_0001);
        do_write(4'd12, 32'hA5A5_0001);
        do_write(4'd5, 32'h0BAD_F00D);
        do_search("R5 three hits", 32'hA5A5_0001);
        do_search("R5 single hit", 32'h0BAD_F00D);
        do_search("R5 miss", 32'h1234_5678);
        do_write(4'd15, 32'hFFFF_FFFF);
        do_search("R8 top slot", 32'hFFFF_FFFF);
    endtask

    task automatic t_small_example;
        do_write(4'd0, 32'h0000_000C);
        do_write(4'd1, 32'h0000_000C);
        do_search("R5 example", 32'h0000_000C);
        check("R5 example low nibble", 64'(vec0[3:0]), 64'h3);
        check("R7 example low nibble", 64'(vec1[3:0]), 64'h1);
        check("R8 example addr", 64'(ad2), 64'd0);
    endtask

    task automatic t_write_while_busy;
        wr_req = 1'b1; wr_idx = 4'd9; wr_word = 32'h0000_9999;
        @(negedge clk);
        wr_idx = 4'd10; wr_word = 32'h0000_AAAA;
        @(negedge clk);
        wr_req = 1'b0;
        check_busy("R3 after ignored", 1'b0);
        m_data[9] = 32'h0000_9999; m_val[9] = 1'b1;
        do_search("R3 ignored word absent", 32'h0000_AAAA);
        do_search("R3 first word present", 32'h0000_9999);
    endtask

    task automatic t_refuse;
        wr_req = 1'b1; wr_idx = 4'd6; wr_word = 32'h0000_0666;
        @(negedge clk);
        wr_req = 1'b0;
        srch_req = 1'b1; srch_key = 32'h0000_0666;
        check("R4 ready low while busy", 64'({rdy0, rdy1, rdy2}), 64'd0);
        @(negedge clk);
        srch_req = 1'b0;
        check("R4 refused search no strobe", 64'({v0, v1, v2}), 64'd0);
        m_data[6] = 32'h0000_0666; m_val[6] = 1'b1;
        do_search("R2 searchable after commit", 32'h0000_0666);
        @(negedge clk);
        check("R4 strobe one cycle", 64'({v0, v1, v2}), 64'd0);
        check("R4 result held", 64'(vec0), 64'(16'h0040));
    endtask

    task automatic t_same_cycle;
        wr_req = 1'b1; wr_idx = 4'd2; wr_word = 32'h2222_2222;
        srch_req = 1'b1; srch_key = 32'h2222_2222;
        @(negedge clk);
        wr_req = 1'b0; srch_req = 1'b0;
        check_result("R9 search sees old contents", 32'h2222_2222);
        @(negedge clk);
        m_data[2] = 32'h2222_2222; m_val[2] = 1'b1;
        do_search("R9 later search sees write", 32'h2222_2222);
    endtask

    task automatic t_clear;
        clear_all = 1'b1;
        @(negedge clk);
        clear_all = 1'b0;
        for (int i = 0; i < N; i++) m_val[i] = 1'b0;
        do_search("R6 cleared", 32'hA5A5_0001);
        wr_req = 1'b1; wr_idx = 4'd4; wr_word = 32'h4444_0000;
        @(negedge clk);
        wr_req = 1'b0; clear_all = 1'b1;
        @(negedge clk);
        clear_all = 1'b0;
        check_busy("R6 cancel", 1'b0);
        do_search("R6 cancelled write absent", 32'h4444_0000);
        do_write(4'd8, 32'h0000_0000);
        do_search("R6 zero word in one slot", 32'h0000_0000);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin m_data[i] = '0; m_val[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_multi();
        t_small_example();
        t_write_while_busy();
        t_refuse();
        t_same_cycle();
        t_clear();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule